// File: doc/BRIEF.md
# Serial Host Port for a Segment Display Controller

This block is the host-facing front end of a segment display controller. A host moves four wires: an active-low select, a write strobe, a read strobe and a serial data line. All four are taken into a fast system clock through synchronisers, and the strobes are turned into single-cycle edge events. Each selected transfer starts with a three-bit mode code. The code picks one of three paths: nibble writes into a 192-entry by 4-bit display memory, nibble reads from it, or a stream of 9-bit configuration words.

The display memory sits outside the block, behind a simple port. Writes take effect on the clock edge where `ram_we` is high. Read data on `ram_rdata` is combinational from `ram_addr`. The data line is split into an input, an output and an output enable; the pad sits outside. Configuration words leave through a one-cycle valid strobe.

The controller is a single state machine with these states:
- `ST_OFF`: select is high.
- `ST_ID`: collecting the mode code.
- `ST_AR`: collecting an address for a read.
- `ST_AW`: collecting an address for a write.
- `ST_RDAT`: streaming nibbles out.
- `ST_WDAT`: taking in nibbles, or waiting to see which strobe comes first.
- `ST_MRD`: shifting out the old nibble of a read-modify-write.
- `ST_MWR`: taking in the new nibble of a read-modify-write.
- `ST_CMD`: collecting command words.
- `ST_DROP`: an unknown code was received; everything is ignored until select goes high.

The transitions are:
- Select high sends any state to `ST_OFF`.
- Select low moves `ST_OFF` to `ST_ID`.
- The third code bit moves `ST_ID` to `ST_AR`, `ST_AW`, `ST_CMD` or `ST_DROP`.
- The eighth address bit moves `ST_AR` to `ST_RDAT` and `ST_AW` to `ST_WDAT`.
- A read-strobe fall at a nibble boundary moves `ST_WDAT` to `ST_MRD`.
- The fourth read bit moves `ST_MRD` to `ST_MWR`.
- The fourth write bit moves `ST_MWR` back to `ST_WDAT`.

Top module: `serif_host_port`

## Requirements
- R1: While `cs_n` is high, no transfer takes place and any partial transfer is discarded. After `cs_n` falls, the first three write-strobe bits are always taken as a fresh mode code.
- R2: The mode code is three bits captured on write-strobe rising edges, first bit as the most significant. 3'b110 selects read, 3'b101 selects write (and read-modify-write), and 3'b100 selects command. Any other code makes the block ignore all strobes until `cs_n` rises again: no memory write and no command strobe.
- R3: In write mode, 8 address bits follow the code, most significant first. Then 4 data bits follow, least significant first. `ram_we` is high for exactly one cycle, with `ram_wdata` holding the nibble and `ram_addr` the address.
- R4: Further nibbles with no new address go to the address plus one, plus two, and so on. The address wraps from 191 to 0.
- R5: In read mode, each read-strobe falling edge drives one bit of the nibble at the current address onto `data_out`, least significant first. The address advances after the fourth bit, and reading continues at the next address.
- R6: In 3'b101 mode, a read-strobe falling edge at a nibble boundary shifts the current nibble out (4 bits). The next 4 write-strobe bits then overwrite that same address, and the address advances after that.
- R7: In command mode, each word is 9 bits, most significant first. Each complete word gives a one-cycle `cmd_valid` with the word on `cmd_word`. Further words follow without a new mode code while `cs_n` stays low.
- R8: Addresses 192 to 255 never assert `ram_we` and read back as 4'b0000, whatever `ram_rdata` returns.
- R9: `data_oe` rises only on a read-strobe falling edge in a read path. It is cleared by any write-strobe rising edge and by `cs_n` high.
- R10: After reset, `data_oe`, `cmd_valid` and `ram_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host select, active low, asynchronous to clk |
| wr_clk | input | 1 | Host write strobe; data is taken on its rising edge |
| rd_clk | input | 1 | Host read strobe; data is driven on its falling edge |
| data_in | input | 1 | Serial data from the pad |
| data_out | output | 1 | Serial read data to the pad |
| data_oe | output | 1 | Pad output enable |
| ram_addr | output | 8 | Display memory address |
| ram_we | output | 1 | Display memory write enable |
| ram_wdata | output | 4 | Display memory write nibble |
| ram_rdata | input | 4 | Display memory read nibble, combinational from ram_addr |
| cmd_valid | output | 1 | One-cycle strobe for a complete command word |
| cmd_word | output | 9 | Command word |

## Verification
A wrong bit counter or a wrong state shows up at once as a nibble landing at a neighbouring address. It can also show as a misaligned command word, so the bench compares the whole memory and the command stream after every transfer. A wrong address counter appears on the first nibble after a boundary: at the 191-to-0 wrap, or at the first out-of-range access, where a preloaded marker value would leak through. Bad output-enable or select handling shows within one host half-period on `data_out` and `data_oe`, or as a stray write after an aborted transfer.

// File: rtl/serif_pkg.sv
package serif_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_ID,
        ST_AR,
        ST_AW,
        ST_RDAT,
        ST_WDAT,
        ST_MRD,
        ST_MWR,
        ST_CMD,
        ST_DROP
    } serif_state_t;

    localparam int ID_W = 3;
    localparam logic [ID_W-1:0] ID_READ  = 3'b110;
    localparam logic [ID_W-1:0] ID_WRITE = 3'b101;
    localparam logic [ID_W-1:0] ID_CMD   = 3'b100;

endpackage

// File: rtl/serif_sync.sv
module serif_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ff <= {STAGES{RST_VAL[i]}};
            end else begin
                ff <= {ff[STAGES-2:0], d[i]};
            end
        end
        assign q[i] = ff[STAGES-1];
    end

endmodule

// File: rtl/serif_edge.sv
module serif_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic hit
);

    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b1;
        end else begin
            prev <= sig;
        end
    end

    if (RISING) begin : g_rise
        assign hit = sig & ~prev;
    end else begin : g_fall
        assign hit = ~sig & prev;
    end

endmodule

// File: rtl/serif_addr_ctr.sv
module serif_addr_ctr #(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              in_range
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
        end
    end

    assign in_range = (addr <= LAST);

endmodule

// File: rtl/serif_host_port.sv
module serif_host_port
    import serif_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 4,
    parameter int CMD_W       = 9,
    parameter int RAM_DEPTH   = 192,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              data_in,
    output logic              data_out,
    output logic              data_oe,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_word
);

    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ID_LAST   = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] NIB_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);

    // synchronised pins: {cs_n, wr_clk, rd_clk, data_in}
    logic [3:0] pins_q;
    logic       s_csn, s_wr, s_rd, s_din;
    logic       wr_rise, rd_fall;

    serif_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1111)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, wr_clk, rd_clk, data_in}),
        .q     (pins_q)
    );
    assign {s_csn, s_wr, s_rd, s_din} = pins_q;

    serif_edge #(.RISING(1'b1)) wr_edge_i (
        .clk (clk), .rst_n (rst_n), .sig (s_wr), .hit (wr_rise)
    );
    serif_edge #(.RISING(1'b0)) rd_edge_i (
        .clk (clk), .rst_n (rst_n), .sig (s_rd), .hit (rd_fall)
    );

    serif_state_t         state, nxt;
    logic [CNT_W-1:0]     cnt;
    logic [CMD_W-2:0]     shreg;
    logic [DATA_W-2:0]    nib;
    logic                 addr_load, addr_step, nib_done, in_range;
    logic [DATA_W-1:0]    rd_val;
    logic [ID_W-1:0]      id_word;

    assign id_word = {shreg[ID_W-2:0], s_din};

    // next-state logic
    always_comb begin
        nxt = state;
        if (s_csn) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = ST_ID;
                ST_ID: begin
                    if (wr_rise && cnt == ID_LAST) begin
                        if (id_word == ID_READ)       nxt = ST_AR;
                        else if (id_word == ID_WRITE) nxt = ST_AW;
                        else if (id_word == ID_CMD)   nxt = ST_CMD;
                        else                          nxt = ST_DROP;
                    end
                end
                ST_AR:   if (wr_rise && cnt == ADDR_LAST) nxt = ST_RDAT;
                ST_AW:   if (wr_rise && cnt == ADDR_LAST) nxt = ST_WDAT;
                ST_WDAT: if (rd_fall && cnt == '0)        nxt = ST_MRD;
                ST_MRD:  if (rd_fall && cnt == NIB_LAST)  nxt = ST_MWR;
                ST_MWR:  if (wr_rise && cnt == NIB_LAST)  nxt = ST_WDAT;
                ST_RDAT, ST_CMD, ST_DROP: nxt = state;
                default: nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // address and memory control
    assign addr_load = !s_csn && wr_rise && cnt == ADDR_LAST &&
                       (state == ST_AR || state == ST_AW);
    assign nib_done  = !s_csn && wr_rise && cnt == NIB_LAST &&
                       (state == ST_WDAT || state == ST_MWR);
    assign addr_step = nib_done ||
                       (!s_csn && rd_fall && cnt == NIB_LAST && state == ST_RDAT);
    assign ram_we    = nib_done && in_range;
    assign ram_wdata = {s_din, nib};
    assign rd_val    = in_range ? ram_rdata : '0;

    serif_addr_ctr #(.ADDR_W(ADDR_W), .DEPTH(RAM_DEPTH)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_val ({shreg[ADDR_W-2:0], s_din}),
        .step     (addr_step),
        .addr     (ram_addr),
        .in_range (in_range)
    );

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            nib       <= '0;
            data_out  <= 1'b0;
            data_oe   <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (s_csn) begin
                cnt     <= '0;
                data_oe <= 1'b0;
            end else begin
                if (wr_rise) data_oe <= 1'b0;
                unique case (state)
                    ST_ID: begin
                        if (wr_rise) begin
                            shreg <= {shreg[CMD_W-3:0], s_din};
                            cnt   <= (cnt == ID_LAST) ? '0 : cnt + 1'b1;
                        end
                    end
                    ST_AR, ST_AW: begin
                        if (wr_rise) begin
                            shreg <= {shreg[CMD_W-3:0], s_din};
                            cnt   <= (cnt == ADDR_LAST) ? '0 : cnt + 1'b1;
                        end
                    end
                    ST_CMD: begin
                        if (wr_rise) begin
                            shreg <= {shreg[CMD_W-3:0], s_din};
                            if (cnt == CMD_LAST) begin
                                cnt       <= '0;
                                cmd_valid <= 1'b1;
                                cmd_word  <= {shreg, s_din};
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_WDAT, ST_MWR: begin
                        if (wr_rise) begin
                            nib <= {s_din, nib[DATA_W-2:1]};
                            cnt <= (cnt == NIB_LAST) ? '0 : cnt + 1'b1;
                        end else if (rd_fall && state == ST_WDAT && cnt == '0) begin
                            data_out <= rd_val[0];
                            data_oe  <= 1'b1;
                            cnt      <= CNT_W'(1);
                        end
                    end
                    ST_MRD, ST_RDAT: begin
                        if (rd_fall) begin
                            data_out <= rd_val[cnt[BIT_W-1:0]];
                            data_oe  <= 1'b1;
                            cnt      <= (cnt == NIB_LAST) ? '0 : cnt + 1'b1;
                        end
                    end
                    default: begin
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/serif_host_port_chk.sv
module serif_host_port_chk #(
    parameter int ADDR_W    = 8,
    parameter int RAM_DEPTH = 192
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_q,
    input logic              rd_fall,
    input logic              data_oe,
    input logic              cmd_valid,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr
);

    assert_we_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ({1'b0, ram_addr} < (ADDR_W+1)'(RAM_DEPTH)));

    assert_we_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we);

    assert_cmd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_cmd_no_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !data_oe);

    assert_oe_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !data_oe);

    assert_oe_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> $past(rd_fall));

endmodule

bind serif_host_port serif_host_port_chk #(
    .ADDR_W    (ADDR_W),
    .RAM_DEPTH (RAM_DEPTH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_q      (s_csn),
    .rd_fall   (rd_fall),
    .data_oe   (data_oe),
    .cmd_valid (cmd_valid),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr)
);

// File: tb/serif_host_port_tb_top.sv
module serif_host_port_tb_top;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_clk = 1'b1, rd_clk = 1'b1, data_in = 1'b1;
    logic       data_out, data_oe, ram_we, cmd_valid;
    logic [7:0] ram_addr;
    logic [3:0] ram_wdata, ram_rdata;
    logic [8:0] cmd_word;

    always #2 clk = ~clk;

    serif_host_port dut_i (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .wr_clk (wr_clk),
        .rd_clk (rd_clk), .data_in (data_in), .data_out (data_out),
        .data_oe (data_oe), .ram_addr (ram_addr), .ram_we (ram_we),
        .ram_wdata (ram_wdata), .ram_rdata (ram_rdata),
        .cmd_valid (cmd_valid), .cmd_word (cmd_word)
    );

    // behavioural display memory; unused addresses hold a marker
    logic [3:0] ram_mem [0:255];
    logic [3:0] exp_mem [0:255];
    assign ram_rdata = ram_mem[ram_addr];
    always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= ram_wdata;

    logic [8:0] cmd_q[$];
    logic [8:0] exp_cmd[$];
    int         cmd_long = 0;
    logic       prev_valid = 1'b0;
    always @(posedge clk) begin
        if (rst_n && cmd_valid) cmd_q.push_back(cmd_word);
        if (rst_n && cmd_valid && prev_valid) cmd_long++;
        prev_valid <= cmd_valid;
    end

    int checks = 0, errors = 0, m_addr = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();   cs_n = 1'b0; idle(H); endtask
    task automatic desel(); cs_n = 1'b1; idle(H); endtask

    task automatic wbit(input bit b);
        wr_clk = 1'b0; data_in = b; idle(H);
        wr_clk = 1'b1; idle(H);
    endtask

    task automatic send_msb(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) wbit(v[i]);
    endtask

    function automatic int nxt_addr(input int a);
        return (a == 191) ? 0 : ((a + 1) & 255);
    endfunction

    task automatic start(input int id, input int a);
        sel(); send_msb(id, 3); send_msb(a, 8); m_addr = a;
    endtask

    // one nibble, D0 first; model updates the expected memory
    task automatic w_nib(input logic [3:0] n);
        for (int i = 0; i < 4; i++) wbit(n[i]);
        if (m_addr < 192) exp_mem[m_addr] = n;
        m_addr = nxt_addr(m_addr);
    endtask

    task automatic r_nib(input bit adv, input string req);
        logic [3:0] e;
        e = (m_addr < 192) ? exp_mem[m_addr] : 4'h0;
        for (int i = 0; i < 4; i++) begin
            rd_clk = 1'b0; idle(H);
            chk(data_out == e[i] && data_oe, req, {data_oe, data_out}, {1'b1, e[i]});
            rd_clk = 1'b1; idle(H);
        end
        if (adv) m_addr = nxt_addr(m_addr);
    endtask

    task automatic check_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 256; i++) if (ram_mem[i] !== exp_mem[i] && bad < 0) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {bad, 4'h0} | ram_mem[bad], {bad, 4'h0} | exp_mem[bad]);
    endtask

    task automatic check_cmds(input string req);
        bit ok = (cmd_q.size() == exp_cmd.size()) && cmd_long == 0;
        if (ok) foreach (exp_cmd[i]) if (cmd_q[i] !== exp_cmd[i]) ok = 1'b0;
        chk(ok, req, cmd_q.size(), exp_cmd.size());
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram_mem[i] = (i < 192) ? 4'h0 : 4'hA;
            exp_mem[i] = ram_mem[i];
        end
        idle(5);
        // R10: reset values
        chk(!data_oe && !cmd_valid && !ram_we, "R10", {data_oe, cmd_valid, ram_we}, 0);
        rst_n = 1'b1; idle(4);
        chk(!data_oe && !cmd_valid && !ram_we, "R10", {data_oe, cmd_valid, ram_we}, 0);

        // R3 R4: stream of nibbles from 0x05, and to 0x10
        start(3'b101, 8'h05); w_nib(4'h3); w_nib(4'h9); w_nib(4'hE); desel();
        check_mem("R3");
        start(3'b101, 8'h10); w_nib(4'h3); w_nib(4'hC); desel();
        check_mem("R4");
        // R4: wrap from 191 to 0
        start(3'b101, 190); w_nib(4'h1); w_nib(4'h2); w_nib(4'h7); desel();
        check_mem("R4");
        // R8: out-of-range write is dropped
        start(3'b101, 200); w_nib(4'h5); w_nib(4'h6); desel();
        check_mem("R8");

        // R5: successive read
        start(3'b110, 8'h05); r_nib(1, "R5"); r_nib(1, "R5"); r_nib(1, "R5");
        // R9: cs high releases output enable
        desel(); chk(!data_oe, "R9", data_oe, 0);
        // R8: out-of-range read returns zero
        start(3'b110, 254); r_nib(1, "R8"); desel();

        // R6: read-modify-write at 0x10 and 0x11
        start(3'b101, 8'h10);
        r_nib(0, "R6"); w_nib(4'h9);
        chk(!data_oe, "R9", data_oe, 0);
        r_nib(0, "R6"); w_nib(4'h5); desel();
        check_mem("R6");

        // R7: back-to-back commands without a repeated code
        sel(); send_msb(3'b100, 3);
        send_msb(9'h003, 9); exp_cmd.push_back(9'h003);
        send_msb(9'h14B, 9); exp_cmd.push_back(9'h14B);
        send_msb(9'h1C3, 9); exp_cmd.push_back(9'h1C3);
        desel(); check_cmds("R7");

        // R1: aborted address, then a fresh transfer
        sel(); send_msb(3'b101, 3); send_msb(5'b10110, 5); desel();
        start(3'b101, 8'h20); w_nib(4'h7); desel();
        check_mem("R1");
        // R1: aborted command is not emitted
        sel(); send_msb(3'b100, 3); send_msb(5'b11111, 5); desel();
        sel(); send_msb(3'b100, 3); send_msb(9'h0A5, 9); exp_cmd.push_back(9'h0A5); desel();
        check_cmds("R1");

        // R2: unknown code ignores the rest
        sel(); send_msb(3'b111, 3); send_msb(8'h30, 8); send_msb(4'hF, 4);
        send_msb(9'h1FF, 9); desel();
        check_mem("R2"); check_cmds("R2");
        sel(); send_msb(3'b011, 3); send_msb(9'h055, 9); desel();
        check_mem("R2"); check_cmds("R2");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule